// File: doc/BRIEF.md
# Hypercube Node Router with Lowest-Bit-First Path Selection

This block is the switching logic for one node of a binary cube network of 2^DIM nodes. A node links directly to DIM neighbours, and each neighbour's identifier differs from its own in exactly one bit. Link k leads to the neighbour whose identifier has bit k inverted. The node's own identifier is fixed by the parameter `NODE_ID`.

Packets arrive on DIM link inputs and on one local injection input. Every port uses a valid/ready handshake. The router XORs the packet's destination with `NODE_ID` and sends the packet out on the link that corrects the lowest differing bit. A packet already at its destination leaves through the local ejection output. Each output sits behind a one-entry register slice, so a packet moves at most one hop per clock cycle. When several inputs want the same output, a round-robin arbiter picks the winner for each output.

Port numbering is the same on both sides. Indices 0 to DIM-1 are the links, and index DIM is the local port (injection on the input side, ejection on the output side). A packet is `PKT_W` = DIM + HOP_W + PAY_W bits wide, laid out as follows:
- `dest` sits in bits [DIM-1:0].
- The hop count sits in bits [DIM+HOP_W-1:DIM].
- The payload sits above the hop count.

Top module: `hc_router`

## Requirements
- R1: After a synchronous active-high reset, every bit of `out_valid` is 0.
- R2: A packet whose `dest` differs from `NODE_ID` leaves on link output k, where k is the lowest bit position set in `dest ^ NODE_ID`.
- R3: A packet whose `dest` equals `NODE_ID` leaves on output index DIM (local ejection) and never on a link.
- R4: A packet leaving on a link carries its hop count plus one. A packet leaving on the ejection output keeps its hop count unchanged. Payload and `dest` pass through unmodified.
- R5: A packet accepted on a clock edge is valid on its output after that same edge, which is exactly one register stage later.
- R6: Each output accepts at most one input per cycle. The winner is the first requesting input at or after a rotating pointer. The pointer starts at 0 after reset and moves to the winner's index plus one (wrapping) on each accept.
- R7: An input that loses arbitration, or whose output slice is full and stalled, sees `in_ready` low and keeps its packet.
- R8: While an output is valid and its `out_ready` is low, the output stays valid and its packet does not change.
- R9: In a full cube of these nodes, a packet injected at node s for node d is ejected only at node d. Its hop count there equals popcount(s ^ d), so it takes at most DIM hops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | DIM+1 | Per-input valid (links 0..DIM-1, injection at DIM) |
| in_ready | output | DIM+1 | Per-input ready |
| in_pkt | input | (DIM+1)*PKT_W | Input packets, slot i at bits [i*PKT_W +: PKT_W] |
| out_valid | output | DIM+1 | Per-output valid (links 0..DIM-1, ejection at DIM) |
| out_ready | input | DIM+1 | Per-output ready from the downstream receiver |
| out_pkt | output | (DIM+1)*PKT_W | Output packets, slot o at bits [o*PKT_W +: PKT_W] |

## Verification
The assertions assume two things about the inputs. First, an input that raises `in_valid` holds it until accepted. Second, an upstream sender keeps its packet steady while stalled, because the stability check on the outputs only covers what the slice registers. The assertions do not assume that link inputs carry only packets that already agree with this node in lower bits, so the stand-alone node takes arbitrary destinations on any port. The bench keeps to these rules in three ways. It changes inputs only at falling edges, and it drops a valid only after the cycle in which that input was accepted. Its random hop values stay below the largest count that one more hop could still hold. In the cube test, it injects a packet only at the local port and waits for it to be ejected before sending the next one.

// File: rtl/hc_pkg.sv
package hc_pkg;
    localparam int DIM    = 3;
    localparam int PAY_W  = 8;
    localparam int NPORT  = DIM + 1;
    localparam int PORT_W = $clog2(NPORT);
    localparam int HOP_W  = $clog2(DIM + 1);
    localparam int PKT_W  = DIM + HOP_W + PAY_W;
    localparam int NNODE  = 1 << DIM;

    typedef logic [DIM-1:0] node_t;

    typedef struct packed {
        logic [PAY_W-1:0] pay;
        logic [HOP_W-1:0] hops;
        node_t            dest;
    } pkt_t;

    // Output index for a packet at node self heading to dest:
    // the lowest differing bit selects the link; no difference selects ejection.
    function automatic logic [PORT_W-1:0] pick_port(node_t self, node_t dest);
        node_t             diff;
        logic [PORT_W-1:0] p;
        diff = self ^ dest;
        p    = PORT_W'(DIM);
        for (int k = DIM - 1; k >= 0; k--) begin
            if (diff[k]) p = PORT_W'(k);
        end
        return p;
    endfunction
endpackage

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic          any;

    always_comb begin
        gnt = '0;
        win = '0;
        any = 1'b0;
        for (int off = 0; off < N; off++) begin
            int idx;
            idx = int'(ptr) + off;
            if (idx >= N) idx = idx - N;
            if (!any && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = IW'(idx);
                any      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (any && adv) begin
            ptr <= (int'(win) == N - 1) ? '0 : win + 1'b1;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));                                   // R6
    AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);                              // R6
endmodule

// File: rtl/hc_out_slice.sv
module hc_out_slice
    import hc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  pkt_t in_pkt,
    output logic out_valid,
    input  logic out_ready,
    output pkt_t out_pkt
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pkt   <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_pkt <= in_pkt;
        end
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid);           // R8
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(out_pkt));    // R8
endmodule

// File: rtl/hc_router.sv
module hc_router
    import hc_pkg::*;
#(
    parameter node_t NODE_ID = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPORT-1:0]       in_valid,
    output logic [NPORT-1:0]       in_ready,
    input  logic [NPORT*PKT_W-1:0] in_pkt,
    output logic [NPORT-1:0]       out_valid,
    input  logic [NPORT-1:0]       out_ready,
    output logic [NPORT*PKT_W-1:0] out_pkt
);
    pkt_t              ipkt   [NPORT];
    logic [PORT_W-1:0] sel    [NPORT];
    logic [NPORT-1:0]  req    [NPORT];
    logic [NPORT-1:0]  gnt    [NPORT];
    logic [NPORT-1:0]  s_rdy;
    logic [NPORT-1:0]  s_vld;
    pkt_t              s_pkt  [NPORT];
    pkt_t              o_pkt  [NPORT];

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        assign ipkt[i] = pkt_t'(in_pkt[i*PKT_W +: PKT_W]);
        assign sel[i]  = pick_port(NODE_ID, ipkt[i].dest);
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        for (genvar i = 0; i < NPORT; i++) begin : g_req
            assign req[o][i] = in_valid[i] && (sel[i] == PORT_W'(o));
        end

        hc_rr_arb #(.N(NPORT)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (req[o]),
            .adv (s_rdy[o]),
            .gnt (gnt[o])
        );

        always_comb begin
            pkt_t m;
            m = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (gnt[o][i]) m = m | ipkt[i];
            end
            if (o < DIM) m.hops = m.hops + 1'b1;
            s_pkt[o] = m;
        end

        hc_out_slice u_slice (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (|gnt[o]),
            .in_ready  (s_rdy[o]),
            .in_pkt    (s_pkt[o]),
            .out_valid (s_vld[o]),
            .out_ready (out_ready[o]),
            .out_pkt   (o_pkt[o])
        );

        assign out_valid[o]               = s_vld[o];
        assign out_pkt[o*PKT_W +: PKT_W]  = o_pkt[o];

        if (o < DIM) begin : g_link_chk
            AST_LINK_BIT: assert property (@(posedge clk) disable iff (rst)
                s_vld[o] |-> (o_pkt[o].dest[o] != NODE_ID[o]) &&
                   (((o_pkt[o].dest ^ NODE_ID) & node_t'((1 << o) - 1)) == '0)); // R2
        end else begin : g_ej_chk
            AST_EJECT_DEST: assert property (@(posedge clk) disable iff (rst)
                s_vld[o] |-> o_pkt[o].dest == NODE_ID);   // R3
        end
    end

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            in_ready[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) begin
                if (gnt[o][i] && s_rdy[o]) in_ready[i] = 1'b1;
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> out_valid == '0);                  // R1
endmodule

// File: tb/hc_router_tb.sv
`timescale 1ns/1ps
module hc_router_tb;
    import hc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam node_t UID = node_t'(5);

    logic [NPORT-1:0]       u_iv, u_ir, u_ov, u_or;
    logic [NPORT*PKT_W-1:0] u_ip, u_op;

    hc_router #(.NODE_ID(UID)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(u_iv), .in_ready(u_ir), .in_pkt(u_ip),
        .out_valid(u_ov), .out_ready(u_or), .out_pkt(u_op)
    );

    // Full cube of nodes for end-to-end checks.
    logic [NPORT-1:0]       c_iv [NNODE];
    logic [NPORT-1:0]       c_ir [NNODE];
    logic [NPORT*PKT_W-1:0] c_ip [NNODE];
    logic [NPORT-1:0]       c_ov [NNODE];
    logic [NPORT-1:0]       c_or [NNODE];
    logic [NPORT*PKT_W-1:0] c_op [NNODE];
    logic [DIM-1:0]         c_lv [NNODE];
    logic [DIM-1:0]         c_lr [NNODE];
    logic [DIM*PKT_W-1:0]   c_lp [NNODE];
    logic                   inj_v [NNODE];
    pkt_t                   inj_p [NNODE];

    for (genvar a = 0; a < NNODE; a++) begin : g_cube
        for (genvar k = 0; k < DIM; k++) begin : g_lnk
            assign c_lv[a][k] = c_ov[a ^ (1 << k)][k];
            assign c_lr[a][k] = c_ir[a ^ (1 << k)][k];
            assign c_lp[a][k*PKT_W +: PKT_W] = c_op[a ^ (1 << k)][k*PKT_W +: PKT_W];
        end
        assign c_iv[a] = {inj_v[a], c_lv[a]};
        assign c_or[a] = {1'b1, c_lr[a]};
        assign c_ip[a] = {inj_p[a], c_lp[a]};

        hc_router #(.NODE_ID(node_t'(a))) u_dut (
            .clk(clk), .rst(rst),
            .in_valid(c_iv[a]), .in_ready(c_ir[a]), .in_pkt(c_ip[a]),
            .out_valid(c_ov[a]), .out_ready(c_or[a]), .out_pkt(c_op[a])
        );
    end

    function automatic pkt_t mk(int d, int h, int p);
        pkt_t x;
        x.dest = node_t'(d);
        x.hops = HOP_W'(h);
        x.pay  = PAY_W'(p);
        return x;
    endfunction

    function automatic int exp_port(int self, int d);
        int x;
        x = (self ^ d) & (NNODE - 1);
        for (int k = 0; k < DIM; k++) if (x[k]) return k;
        return DIM;
    endfunction

    function automatic int popc(int v);
        int c = 0;
        for (int k = 0; k < DIM; k++) c += v[k];
        return c;
    endfunction

    function automatic pkt_t uslot(int o);
        return pkt_t'(u_op[o*PKT_W +: PKT_W]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic usend(input int inp, input int d, input int h, input int p);
        int   eo;
        pkt_t g;
        eo = exp_port(int'(UID), d);
        @(negedge clk);
        u_iv = '0;
        u_iv[inp] = 1'b1;
        u_ip[inp*PKT_W +: PKT_W] = mk(d, h, p);
        #1;
        chk(u_ir[inp] == 1'b1, "R5 accept", int'(u_ir), 1 << inp);
        @(negedge clk);
        u_iv = '0;
        chk(u_ov == NPORT'(1 << eo), (eo == DIM) ? "R3 port" : "R2 port", int'(u_ov), 1 << eo);
        g = uslot(eo);
        chk(int'(g.hops) == ((eo == DIM) ? h : h + 1), "R4 hops", int'(g.hops), (eo == DIM) ? h : h + 1);
        chk(int'(g.pay) == (p & 8'hFF) && int'(g.dest) == d, "R4 payload", int'(g.pay), p & 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pkt_t g, g0;
        void'($urandom(32'h5EED_1234));
        u_iv = '0; u_ip = '0; u_or = '1;
        for (int a = 0; a < NNODE; a++) begin inj_v[a] = 1'b0; inj_p[a] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(u_ov == '0, "R1 reset", int'(u_ov), 0);

        // Directed routing at node 5 (101).
        usend(DIM, 5, 1, 8'h11);   // R3 eject, hops kept
        usend(DIM, 4, 0, 8'h22);   // R2 diff 001 -> link0
        usend(DIM, 7, 2, 8'h33);   // R2 diff 010 -> link1
        usend(DIM, 1, 0, 8'h44);   // R2 diff 100 -> link2
        usend(0,   2, 1, 8'h55);   // R2 diff 111 -> link0 (lowest)

        // Contention: all inputs to dest 1 (link2), rotating winners 0..3.  R6 R7
        @(negedge clk);
        for (int i = 0; i < NPORT; i++) u_ip[i*PKT_W +: PKT_W] = mk(1, 0, 8'h10 + i);
        u_iv = '1;
        for (int w = 0; w < NPORT; w++) begin
            #1;
            chk(u_ir == NPORT'(1 << w), "R6 R7 rr grant", int'(u_ir), 1 << w);
            @(negedge clk);
            u_iv[w] = 1'b0;
            g = uslot(2);
            chk(u_ov[2] && int'(g.pay) == 8'h10 + w, "R6 winner", int'(g.pay), 8'h10 + w);
        end
        u_iv = 4'b1010;
        #1;
        chk(u_ir == 4'b0010, "R6 rr from 0", int'(u_ir), 2);
        @(negedge clk);
        u_iv = 4'b1001;
        #1;
        chk(u_ir == 4'b1000, "R6 rr wrap", int'(u_ir), 8);
        @(negedge clk);
        u_iv = '0;
        @(negedge clk);

        // Stall: output link1 held.  R8 R7
        u_or[1] = 1'b0;
        u_iv[DIM] = 1'b1;
        u_ip[DIM*PKT_W +: PKT_W] = mk(7, 0, 8'hA1);
        @(negedge clk);
        u_iv = '0;
        g0 = uslot(1);
        u_iv[0] = 1'b1;
        u_ip[0 +: PKT_W] = mk(7, 0, 8'hA2);
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(u_ir[0] == 1'b0, "R7 blocked by full slice", int'(u_ir), 0);
            @(negedge clk);
            g = uslot(1);
            chk(u_ov[1] && g == g0, "R8 hold", int'(g.pay), int'(g0.pay));
        end
        u_or[1] = 1'b1;
        #1;
        chk(u_ir[0] == 1'b1, "R7 released", int'(u_ir), 1);
        @(negedge clk);
        u_iv = '0;
        g = uslot(1);
        chk(u_ov[1] && int'(g.pay) == 8'hA2, "R8 next after release", int'(g.pay), 8'hA2);
        @(negedge clk);

        // Random single-packet routing at node 5.  R2 R3 R4
        for (int n = 0; n < 60; n++) begin
            usend(int'($urandom_range(0, NPORT - 1)), int'($urandom_range(0, NNODE - 1)),
                  int'($urandom_range(0, DIM - 1)), int'($urandom_range(0, 255)));
        end

        // End-to-end in the cube.  R9
        for (int n = 0; n < 41; n++) begin
            int s, d, seen, at, h;
            s = (n == 0) ? 0 : int'($urandom_range(0, NNODE - 1));
            d = (n == 0) ? NNODE - 1 : int'($urandom_range(0, NNODE - 1));
            @(negedge clk);
            inj_p[s] = mk(d, 0, n);
            inj_v[s] = 1'b1;
            #1;
            chk(c_ir[s][DIM] == 1'b1, "R9 inject", int'(c_ir[s][DIM]), 1);
            @(negedge clk);
            inj_v[s] = 1'b0;
            seen = 0; at = -1; h = -1;
            for (int c = 0; c < 3 * DIM + 4; c++) begin
                for (int a = 0; a < NNODE; a++) begin
                    if (c_ov[a][DIM]) begin
                        g = pkt_t'(c_op[a][DIM*PKT_W +: PKT_W]);
                        seen++; at = a; h = int'(g.hops);
                    end
                end
                @(negedge clk);
            end
            chk(seen == 1 && at == d, "R9 delivered at dest", at, d);
            chk(h == popc(s ^ d), "R9 hop count", h, popc(s ^ d));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule